// File: doc/BRIEF.md
# Shadow Fully-Associative Miss Classifier

This block watches a stream of cache line addresses and labels each access as a hit, a conflict miss or a capacity miss. It keeps two tag-only cache models side by side. The first is a set-associative model. The second is a fully-associative model that holds the same number of lines. Both models see every access. A miss that the set-associative model takes, but that the fully-associative model would have served, is caused by the limited number of ways. A miss that both models take is caused by limited capacity.

A monitor drives one line address per cycle with a valid strobe. There is no backpressure. One cycle later the block returns a registered classification. When the set-associative model displaces a valid line, the block also returns the tag of that line. This lets a monitor record which access pushed out which line. Neither model holds any data.

Top module: `miss_classifier`

## Requirements
- R1: An access whose tag is present in the selected set of the set-associative model is classified as a hit, code 2'b00.
- R2: An access that misses in the set-associative model but hits in the fully-associative model is classified as a conflict miss, code 2'b01.
- R3: An access that misses in both models is classified as a capacity miss, code 2'b10. Code 2'b11 never appears.
- R4: Both models use true LRU replacement. A hit makes the line most recently used. A miss fills the lowest-numbered invalid way if one exists, otherwise the least recently used way. The fully-associative model keeps one recency order across all of its lines.
- R5: `evict_valid_o` is high exactly one cycle after a set-associative miss that replaces a valid line, and `evict_tag_o` then carries that line's tag. It is low on hits and on fills into invalid ways.
- R6: `cls_valid_o` is high exactly in the cycle after a cycle with `acc_valid_i` high, and low otherwise. One access is accepted every cycle.
- R7: A synchronous reset invalidates every line in both models and restores the recency state. The first access after reset to any address is a capacity miss with no eviction.
- R8: The low log2(LINES/WAYS) bits of the line address select the set. The remaining upper bits form the set-associative tag. The fully-associative model tags lines by the whole line address.
- R9: Cycles with `acc_valid_i` low leave both models unchanged, whatever value `acc_addr_i` has.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous reset, active high |
| acc_valid_i | input | 1 | Access strobe |
| acc_addr_i | input | ADDR_W | Line address of the access |
| cls_valid_o | output | 1 | Classification valid, one cycle after an access |
| cls_o | output | 2 | 00 hit, 01 conflict miss, 10 capacity miss |
| evict_valid_o | output | 1 | A valid set-associative line was replaced |
| evict_tag_o | output | ADDR_W-log2(LINES/WAYS) | Tag of the replaced line |

## Verification
The assertions assume that `rst_i` is held for at least one clock before the first access. They also assume that `acc_valid_i` and `acc_addr_i` are settled at every rising edge. They do not assume anything about the address values themselves.

The stimulus changes inputs only at falling edges and holds reset across several cycles. It draws addresses from a small pool that spans every set. This keeps hits, conflict misses and capacity misses all frequent. Idle cycles also drive random addresses, so that address values seen while the strobe is low are exercised.

// File: rtl/miss_cls_pkg.sv
package miss_cls_pkg;

    typedef enum logic [1:0] {
        CLS_HIT      = 2'b00,
        CLS_CONFLICT = 2'b01,
        CLS_CAPACITY = 2'b10
    } miss_cls_e;

    // Combine the two model verdicts into one label.
    function automatic miss_cls_e classify(input logic sa_hit, input logic fa_hit);
        if (sa_hit) begin
            return CLS_HIT;
        end
        if (fa_hit) begin
            return CLS_CONFLICT;
        end
        return CLS_CAPACITY;
    endfunction

endpackage

// File: rtl/miss_lru_ages.sv
// True LRU bookkeeping for N entries kept as a permutation of ages.
// Age 0 is the most recently used entry; age N-1 is the least recently used.
module miss_lru_ages #(
    parameter int N  = 4,
    localparam int AW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                 clk_i,
    input  logic                 rst_i,
    input  logic                 touch_i,
    input  logic [AW-1:0]        way_i,
    output logic [N-1:0][AW-1:0] age_o
);

    typedef struct packed {
        logic [N-1:0][AW-1:0] age;
    } lru_state_t;

    lru_state_t st_d, st_q;
    logic [N-1:0] zero_vec;
    logic [N-1:0] oldest_vec;

    always_comb begin
        st_d = st_q;
        if (touch_i) begin
            for (int w = 0; w < N; w++) begin
                if (AW'(w) == way_i) begin
                    st_d.age[w] = '0;
                end else if (st_q.age[w] < st_q.age[way_i]) begin
                    st_d.age[w] = st_q.age[w] + 1'b1;
                end
            end
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            for (int w = 0; w < N; w++) begin
                st_q.age[w] <= AW'(w);
            end
        end else begin
            st_q <= st_d;
        end
    end

    assign age_o = st_q.age;

    always_comb begin
        for (int w = 0; w < N; w++) begin
            zero_vec[w]   = (st_q.age[w] == '0);
            oldest_vec[w] = (st_q.age[w] == AW'(N - 1));
        end
    end

    // R4: a touched entry becomes most recently used
    p_mru_after_touch_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        touch_i |=> (st_q.age[$past(way_i)] == '0));

    // R4: exactly one most recent entry at any time
    p_single_mru_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(zero_vec));

    // R4: exactly one least recent entry at any time
    p_single_lru_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot(oldest_vec));

endmodule

// File: rtl/miss_sa_model.sv
// Tag-only set-associative cache model with per-set true LRU.
module miss_sa_model #(
    parameter int SETS  = 4,
    parameter int WAYS  = 4,
    parameter int IDX_W = 2,
    parameter int TAG_W = 10,
    localparam int AW = (WAYS > 1) ? $clog2(WAYS) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             acc_i,
    input  logic [IDX_W-1:0] idx_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o,
    output logic             evict_valid_o,
    output logic [TAG_W-1:0] evict_tag_o
);

    typedef struct packed {
        logic [SETS-1:0][WAYS-1:0]            vld;
        logic [SETS-1:0][WAYS-1:0][TAG_W-1:0] tag;
    } sa_state_t;

    sa_state_t st_d, st_q;

    logic [WAYS-1:0]                  hit_vec;
    logic [AW-1:0]                    hit_way;
    logic [AW-1:0]                    vic_way;
    logic [AW-1:0]                    touch_way;
    logic                             hit;
    logic                             has_free;
    logic [SETS-1:0][WAYS-1:0][AW-1:0] ages;

    generate
        for (genvar s = 0; s < SETS; s++) begin : g_set_lru
            miss_lru_ages #(.N(WAYS)) u_lru (
                .clk_i   (clk_i),
                .rst_i   (rst_i),
                .touch_i (acc_i && (idx_i == IDX_W'(s))),
                .way_i   (touch_way),
                .age_o   (ages[s])
            );
        end
    endgenerate

    always_comb begin
        st_d    = st_q;
        hit_vec = '0;
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (st_q.vld[idx_i][w] && (st_q.tag[idx_i][w] == tag_i)) begin
                hit_vec[w] = 1'b1;
                hit_way    = AW'(w);
            end
        end
        hit = |hit_vec;

        // Victim: lowest free way, else the least recently used way.
        has_free = 1'b0;
        vic_way  = '0;
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (ages[idx_i][w] == AW'(WAYS - 1)) begin
                vic_way = AW'(w);
            end
        end
        for (int w = WAYS - 1; w >= 0; w--) begin
            if (!st_q.vld[idx_i][w]) begin
                has_free = 1'b1;
                vic_way  = AW'(w);
            end
        end

        touch_way     = hit ? hit_way : vic_way;
        evict_valid_o = acc_i && !hit && !has_free;
        evict_tag_o   = st_q.tag[idx_i][vic_way];

        if (acc_i && !hit) begin
            st_d.vld[idx_i][vic_way] = 1'b1;
            st_d.tag[idx_i][vic_way] = tag_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = hit;

    // R1: a tag is resident in at most one way of a set
    p_sa_unique_tag_r1: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(hit_vec));

    // R4: a miss leaves the missed tag resident in its set
    p_sa_fill_r4: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_i && !hit) |=> st_q.vld[$past(idx_i)][$past(vic_way)]);

endmodule

// File: rtl/miss_fa_model.sv
// Tag-only fully-associative cache model with one global true LRU order.
module miss_fa_model #(
    parameter int LINES = 16,
    parameter int TAG_W = 12,
    localparam int AW = (LINES > 1) ? $clog2(LINES) : 1
) (
    input  logic             clk_i,
    input  logic             rst_i,
    input  logic             acc_i,
    input  logic [TAG_W-1:0] tag_i,
    output logic             hit_o
);

    typedef struct packed {
        logic [LINES-1:0]            vld;
        logic [LINES-1:0][TAG_W-1:0] tag;
    } fa_state_t;

    fa_state_t st_d, st_q;

    logic [LINES-1:0]         hit_vec;
    logic [AW-1:0]            hit_way;
    logic [AW-1:0]            vic_way;
    logic [AW-1:0]            touch_way;
    logic                     hit;
    logic [LINES-1:0][AW-1:0] ages;

    miss_lru_ages #(.N(LINES)) u_lru (
        .clk_i   (clk_i),
        .rst_i   (rst_i),
        .touch_i (acc_i),
        .way_i   (touch_way),
        .age_o   (ages)
    );

    always_comb begin
        st_d    = st_q;
        hit_vec = '0;
        hit_way = '0;
        for (int w = 0; w < LINES; w++) begin
            if (st_q.vld[w] && (st_q.tag[w] == tag_i)) begin
                hit_vec[w] = 1'b1;
                hit_way    = AW'(w);
            end
        end
        hit = |hit_vec;

        vic_way = '0;
        for (int w = LINES - 1; w >= 0; w--) begin
            if (ages[w] == AW'(LINES - 1)) begin
                vic_way = AW'(w);
            end
        end
        for (int w = LINES - 1; w >= 0; w--) begin
            if (!st_q.vld[w]) begin
                vic_way = AW'(w);
            end
        end

        touch_way = hit ? hit_way : vic_way;

        if (acc_i && !hit) begin
            st_d.vld[vic_way] = 1'b1;
            st_d.tag[vic_way] = tag_i;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign hit_o = hit;

    // R8: each full line address is resident at most once
    p_fa_unique_tag_r8: assert property (@(posedge clk_i) disable iff (rst_i)
        $onehot0(hit_vec));

    // R9: without an access the model contents hold still
    p_fa_idle_hold_r9: assert property (@(posedge clk_i) disable iff (rst_i)
        !acc_i |=> $stable(st_q));

endmodule

// File: rtl/miss_classifier.sv
// Runs a set-associative and a same-capacity fully-associative tag model
// together and labels every access as hit, conflict miss or capacity miss.
module miss_classifier
    import miss_cls_pkg::*;
#(
    parameter int ADDR_W = 12,
    parameter int LINES  = 16,
    parameter int WAYS   = 4
) (
    input  logic                                       clk_i,
    input  logic                                       rst_i,
    input  logic                                       acc_valid_i,
    input  logic [ADDR_W-1:0]                          acc_addr_i,
    output logic                                       cls_valid_o,
    output logic [1:0]                                 cls_o,
    output logic                                       evict_valid_o,
    output logic [ADDR_W-$clog2(LINES/WAYS)-1:0]       evict_tag_o
);

    localparam int SETS  = LINES / WAYS;
    localparam int IDX_W = $clog2(SETS);
    localparam int TAG_W = ADDR_W - IDX_W;

    typedef struct packed {
        logic             vld;
        miss_cls_e        cls;
        logic             ev_vld;
        logic [TAG_W-1:0] ev_tag;
    } out_state_t;

    out_state_t st_d, st_q;

    logic             sa_hit;
    logic             fa_hit;
    logic             sa_ev_vld;
    logic [TAG_W-1:0] sa_ev_tag;

    miss_sa_model #(
        .SETS  (SETS),
        .WAYS  (WAYS),
        .IDX_W (IDX_W),
        .TAG_W (TAG_W)
    ) u_sa (
        .clk_i         (clk_i),
        .rst_i         (rst_i),
        .acc_i         (acc_valid_i),
        .idx_i         (acc_addr_i[IDX_W-1:0]),
        .tag_i         (acc_addr_i[ADDR_W-1:IDX_W]),
        .hit_o         (sa_hit),
        .evict_valid_o (sa_ev_vld),
        .evict_tag_o   (sa_ev_tag)
    );

    miss_fa_model #(
        .LINES (LINES),
        .TAG_W (ADDR_W)
    ) u_fa (
        .clk_i (clk_i),
        .rst_i (rst_i),
        .acc_i (acc_valid_i),
        .tag_i (acc_addr_i),
        .hit_o (fa_hit)
    );

    always_comb begin
        st_d        = st_q;
        st_d.vld    = acc_valid_i;
        st_d.ev_vld = sa_ev_vld;
        if (acc_valid_i) begin
            st_d.cls    = classify(sa_hit, fa_hit);
            st_d.ev_tag = sa_ev_tag;
        end
    end

    always_ff @(posedge clk_i) begin
        if (rst_i) begin
            st_q <= '{vld: 1'b0, cls: CLS_HIT, ev_vld: 1'b0, ev_tag: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign cls_valid_o   = st_q.vld;
    assign cls_o         = st_q.cls;
    assign evict_valid_o = st_q.ev_vld;
    assign evict_tag_o   = st_q.ev_tag;

    // R6: every accepted access yields a result on the next cycle
    p_result_follows_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        acc_valid_i |=> cls_valid_o);

    // R6: no result without an access in the cycle before
    p_no_spurious_r6: assert property (@(posedge clk_i) disable iff (rst_i)
        !acc_valid_i |=> !cls_valid_o);

    // R3: only the three defined codes appear
    p_code_legal_r3: assert property (@(posedge clk_i) disable iff (rst_i)
        cls_valid_o |-> (cls_o != 2'b11));

    // R5: an eviction is only reported alongside a miss result
    p_evict_on_miss_r5: assert property (@(posedge clk_i) disable iff (rst_i)
        evict_valid_o |-> (cls_valid_o && (cls_o != CLS_HIT)));

    // R2: a conflict miss means the fully-associative model had the line
    p_conflict_source_r2: assert property (@(posedge clk_i) disable iff (rst_i)
        (acc_valid_i && !sa_hit && fa_hit) |=> (cls_o == CLS_CONFLICT));

endmodule

// File: tb/miss_classifier_test.sv
module miss_classifier_test;

    localparam int ADDR_W = 12;
    localparam int LINES  = 16;
    localparam int WAYS   = 4;
    localparam int SETS   = LINES / WAYS;
    localparam int TAG_W  = ADDR_W - 2;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic              vi  = 1'b0;
    logic [ADDR_W-1:0] ad  = '0;
    logic              cls_valid;
    logic [1:0]        cls;
    logic              ev_valid;
    logic [TAG_W-1:0]  ev_tag;

    int checks = 0;
    int errors = 0;
    int cycles = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;

    miss_classifier #(.ADDR_W(ADDR_W), .LINES(LINES), .WAYS(WAYS)) uut (
        .clk_i         (clk),
        .rst_i         (rst),
        .acc_valid_i   (vi),
        .acc_addr_i    (ad),
        .cls_valid_o   (cls_valid),
        .cls_o         (cls),
        .evict_valid_o (ev_valid),
        .evict_tag_o   (ev_tag)
    );

    // Reference models: timestamp-based LRU
    bit         sa_v [SETS][WAYS];
    int         sa_t [SETS][WAYS];
    int         sa_s [SETS][WAYS];
    bit         fa_v [LINES];
    int         fa_t [LINES];
    int         fa_s [LINES];
    int         now_t;

    task automatic ref_clear();
        for (int s = 0; s < SETS; s++) begin
            for (int w = 0; w < WAYS; w++) begin
                sa_v[s][w] = 1'b0; sa_t[s][w] = 0; sa_s[s][w] = 0;
            end
        end
        for (int w = 0; w < LINES; w++) begin
            fa_v[w] = 1'b0; fa_t[w] = 0; fa_s[w] = 0;
        end
        now_t = 1;
    endtask

    task automatic ref_access(input int a, output int c, output bit ev, output int et);
        int  s;
        int  t;
        int  vic;
        bit  sh;
        bit  fh;
        s  = a % SETS;
        t  = a / SETS;
        sh = 1'b0; fh = 1'b0; ev = 1'b0; et = 0;
        now_t++;
        for (int w = 0; w < WAYS; w++) begin
            if (sa_v[s][w] && sa_t[s][w] == t) begin
                sh = 1'b1; sa_s[s][w] = now_t;
            end
        end
        if (!sh) begin
            vic = -1;
            for (int w = 0; w < WAYS; w++) begin
                if (vic < 0 && !sa_v[s][w]) vic = w;
            end
            if (vic < 0) begin
                vic = 0;
                for (int w = 1; w < WAYS; w++) begin
                    if (sa_s[s][w] < sa_s[s][vic]) vic = w;
                end
                ev = 1'b1; et = sa_t[s][vic];
            end
            sa_v[s][vic] = 1'b1; sa_t[s][vic] = t; sa_s[s][vic] = now_t;
        end
        for (int w = 0; w < LINES; w++) begin
            if (fa_v[w] && fa_t[w] == a) begin
                fh = 1'b1; fa_s[w] = now_t;
            end
        end
        if (!fh) begin
            vic = -1;
            for (int w = 0; w < LINES; w++) begin
                if (vic < 0 && !fa_v[w]) vic = w;
            end
            if (vic < 0) begin
                vic = 0;
                for (int w = 1; w < LINES; w++) begin
                    if (fa_s[w] < fa_s[vic]) vic = w;
                end
            end
            fa_v[vic] = 1'b1; fa_t[vic] = a; fa_s[vic] = now_t;
        end
        c = sh ? 0 : (fh ? 1 : 2);
    endtask

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string cls_req(input int c);
        if (c == 0) return "R1";
        if (c == 1) return "R2";
        return "R3";
    endfunction

    // Called at a falling edge; returns at the next falling edge.
    task automatic access(input int a, input int must_cls, output int got_cls,
                          output int got_tag);
        int c;
        bit ev;
        int et;
        vi = 1'b1;
        ad = ADDR_W'(a);
        ref_access(a, c, ev, et);
        @(negedge clk);
        vi = 1'b0;
        check("R6 valid", int'(cls_valid), 1);
        check(cls_req(c), int'(cls), c);
        if (must_cls >= 0) check({cls_req(must_cls), " directed"}, int'(cls), must_cls);
        check("R5 evict valid", int'(ev_valid), int'(ev));
        if (ev) check("R5 evict tag", int'(ev_tag), et);
        got_cls = int'(cls);
        got_tag = int'(ev_tag);
    endtask

    task automatic idle();
        vi = 1'b0;
        ad = ADDR_W'($urandom);
        @(negedge clk);
        check("R9 idle no result", int'(cls_valid), 0);
    endtask

    task automatic do_reset();
        rst = 1'b1;
        vi  = 1'b0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        ref_clear();
        @(negedge clk);
        check("R7 reset valid", int'(cls_valid), 0);
        check("R7 reset evict", int'(ev_valid), 0);
    endtask

    initial begin
        int gc;
        int gt;
        void'($urandom(32'd20240611));
        @(negedge clk);
        do_reset();

        // R7: first touch after reset is a capacity miss
        access('h100, 2, gc, gt);
        check("R7 no evict", int'(ev_valid), 0);
        access('h100, 0, gc, gt);               // R1 hit
        access('h104, 2, gc, gt);
        access('h108, 2, gc, gt);
        access('h10C, 2, gc, gt);
        check("R4 fill free way", int'(ev_valid), 0);
        access('h110, 2, gc, gt);               // set 0 full: evicts tag of 0x100
        check("R5 lru victim", gt, 'h040);
        access('h100, 1, gc, gt);               // R2 conflict: FA still has it
        check("R4 lru victim 2", gt, 'h041);
        idle();
        idle();
        access('h104, 1, gc, gt);               // R9 idle kept state; conflict

        // R4: a hit refreshes recency (set 1)
        do_reset();
        access('h201, 2, gc, gt);
        access('h205, 2, gc, gt);
        access('h209, 2, gc, gt);
        access('h20D, 2, gc, gt);
        access('h201, 0, gc, gt);
        access('h211, 2, gc, gt);
        check("R4 hit made mru", gt, 'h081);

        // R3: cyclic sweep larger than capacity misses in both models
        do_reset();
        for (int p = 0; p < 2; p++) begin
            for (int i = 0; i < 20; i++) begin
                access('h300 + i, (p == 1) ? 2 : -1, gc, gt);
            end
        end

        // R8: same set bits, different upper bits are distinct lines
        do_reset();
        access('h002, 2, gc, gt);
        access('h802, 2, gc, gt);
        access('h002, 0, gc, gt);

        // Random mix
        do_reset();
        for (int n = 0; n < 4000; n++) begin
            if ($urandom_range(3) == 0) begin
                idle();
            end else begin
                access(int'($urandom_range(39)) * 5 + 'h400, -1, gc, gt);
            end
        end

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles > 100000 && !done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule